// File: doc/BRIEF.md
# ATA PIO Sector Transfer Sequencer

This block carries out one programmed-I/O read or write of 1 to 256 sectors against an ATA drive. It reaches the drive through a simple one-cycle register-access port and moves sector data through valid/ready streams. It uses a source stream for writes and a sink stream for reads. A host pulses `start` with the direction, the drive entry (channel, slave select, LBA capability) and a 32-bit block address with a sector count.

For each request the block picks one of three addressing schemes. It masks drive interrupts, waits until the drive is idle, and fills the task file. Then it issues the matching command. Before every sector it waits about 400 ns by reading alternate status and polls status until the drive is no longer busy. A read stops at the first failed check, and that check's code is returned. A write ends with a cache flush that is polled in the same way. The end of the operation is marked by a one-cycle `done` pulse carrying a 2-bit error code.

The register select values used on `io_sel` are: 0 data word, 2 sector count, 3 to 5 the three address bytes, 6 drive/head, 7 command (write) or status (read), and 8 device control (write) or alternate status (read). Status bits are BSY = bit 7, DF = bit 5, DRQ = bit 3 and ERR = bit 0.

Top module: `ata_pio_seq`

## Requirements
- R1: The addressing mode is LBA48 when the address is 0x10000000 or higher, whatever the capability flag says. Below that it is LBA28 when `drv_lba_ok` is 1, and CHS otherwise. The drive/head byte is 0xE0 for either LBA mode and 0xA0 for CHS. It is ORed with the slave bit in bit 4 and with a nibble in bits 3:0: the CHS head, LBA bits 27:24 for LBA28, or 0 for LBA48.
- R2: In CHS mode, register 3 gets sector = (lba mod 63) + 1. Registers 4 and 5 get the low and high bytes of cylinder = (lba + 1 − sector) / 1008. The head is ((lba + 1 − sector) mod 1008) / 63. In LBA modes, registers 3, 4 and 5 get address bytes 0, 1 and 2.
- R3: In LBA48 mode, four high-half writes come first: count high byte to register 2, address byte 3 to register 3, and zero to registers 4 and 5. The count low byte and address bytes 0 to 2 follow, on the same registers in the same order. The count high byte is 1 for a count of 256 and 0 otherwise. The other modes write register 2 once.
- R4: The command byte written to register 7 is 0x20 for a read and 0x30 for a write, or 0x24 and 0x34 in LBA48 mode.
- R5: After the last written sector, a flush command is written to register 7: 0xEA in LBA48 mode and 0xE7 otherwise. A read writes register 7 only once.
- R6: Each sector poll, and the poll after the flush, reads alternate status (register 8) exactly 4 times. It then reads status until BSY reads 0.
- R7: On a read, the status that ends the poll decides the outcome. ERR set gives code 2. DF set with ERR clear gives code 1. DRQ clear with ERR and DF clear gives code 3. Any nonzero code ends the operation before any data word. On writes the status bits other than BSY are ignored.
- R8: A count of 0 means 256 sectors. Every sector moves exactly 256 words, in stream order, through register 0.
- R9: Before the drive/head write, the block writes 0x02 to register 8 and reads status until BSY is clear.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold steady.
- R11: `done` is high for exactly one cycle per operation. The error code is 0 for every successful read and for every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| dir_wr | input | 1 | 1 = write to drive, 0 = read |
| drv_chan | input | 1 | Channel of the drive |
| drv_slave | input | 1 | Slave select of the drive |
| drv_lba_ok | input | 1 | Drive supports LBA addressing |
| lba | input | 32 | Starting block address |
| nsect | input | 8 | Sector count, 0 = 256 |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code, valid with done |
| io_req | output | 1 | Register access this cycle |
| io_we | output | 1 | 1 = register write, 0 = read |
| io_chan | output | 1 | Channel addressed |
| io_sel | output | 4 | Register select |
| io_wdata | output | 16 | Write data (bytes in bits 7:0) |
| io_rdata | input | 16 | Read data, same cycle as the request |
| m_valid | output | 1 | Read word available |
| m_ready | input | 1 | Sink accepts read word |
| m_data | output | 16 | Read word |
| s_valid | input | 1 | Write word available |
| s_ready | output | 1 | Block accepts write word |
| s_data | input | 16 | Write word |

## Verification
The hardest situations to reach are the read-check codes and their priority when several status bits are set at once. They sit behind the command issue, the delay reads and a busy phase, so a drive model returns BSY for a few status reads after each command and each sector. It then returns a chosen final status byte, and that byte is set per run to ERR alone, DF alone, DRQ clear, and ERR with DF. The CHS arithmetic is driven with addresses whose sector, head and cylinder are all nonzero, and the LBA28/LBA48 edge is hit at 0x0FFFFFFF and 0x10000000. A 256-sector write exercises the zero-count case.

// File: rtl/ata_pio_seq.sv
module ata_pio_seq #(
  parameter int SECT_WORDS  = 256,
  parameter int DELAY_READS = 4,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_wr,
  input  logic              drv_chan,
  input  logic              drv_slave,
  input  logic              drv_lba_ok,
  input  logic [31:0]       lba,
  input  logic [CNT_W-1:0]  nsect,
  output logic              done,
  output logic [1:0]        err,
  output logic              io_req,
  output logic              io_we,
  output logic              io_chan,
  output logic [3:0]        io_sel,
  output logic [15:0]       io_wdata,
  input  logic [15:0]       io_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [15:0]       m_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [15:0]       s_data
);
  localparam int WCW = $clog2(SECT_WORDS);
  localparam int DCW = (DELAY_READS > 1) ? $clog2(DELAY_READS) : 1;
  localparam int SCW = CNT_W + 1;
  localparam logic [1:0] M_CHS = 2'd0, M_L28 = 2'd1, M_L48 = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_WBSY, S_DEV, S_PARM, S_CMD, S_DLY, S_STAT,
    S_RDW, S_RDO, S_WRW, S_FLUSH, S_DONE
  } st_t;

  st_t              st;
  logic             dir_q, chan_q, slave_q, flushing;
  logic [31:0]      lba_q;
  logic [CNT_W-1:0] nsect_q;
  logic [1:0]       mode_q;
  logic [SCW-1:0]   sec_left;
  logic [WCW-1:0]   wcnt;
  logic [DCW-1:0]   dcnt;
  logic [2:0]       pidx;
  logic [15:0]      word_q;

  logic [7:0]  rd, sect, devsel, parm, cmd, flush_cmd;
  logic [31:0] base;
  logic [15:0] cyl;
  logic [3:0]  head, nib;
  logic        word_last, sec_end, is48;

  assign rd        = io_rdata[7:0];
  assign is48      = (mode_q == M_L48);
  assign sect      = 8'(lba_q % 32'd63) + 8'd1;
  assign base      = lba_q - (lba_q % 32'd63);
  assign cyl       = 16'(base / 32'd1008);
  assign head      = 4'((base % 32'd1008) / 32'd63);
  assign nib       = (mode_q == M_CHS) ? head : (mode_q == M_L28) ? lba_q[27:24] : 4'h0;
  assign devsel    = ((mode_q == M_CHS) ? 8'hA0 : 8'hE0) | {3'b000, slave_q, nib};
  assign cmd       = dir_q ? (is48 ? 8'h34 : 8'h30) : (is48 ? 8'h24 : 8'h20);
  assign flush_cmd = is48 ? 8'hEA : 8'hE7;
  assign word_last = (wcnt == WCW'(SECT_WORDS - 1));
  assign sec_end   = word_last && ((st == S_RDO && m_ready) || (st == S_WRW && s_valid));

  always_comb begin
    case (pidx)
      3'd0:    parm = (nsect_q == '0) ? 8'h01 : 8'h00;
      3'd1:    parm = lba_q[31:24];
      3'd4:    parm = 8'(nsect_q);
      3'd5:    parm = (mode_q == M_CHS) ? sect : lba_q[7:0];
      3'd6:    parm = (mode_q == M_CHS) ? cyl[7:0] : lba_q[15:8];
      3'd7:    parm = (mode_q == M_CHS) ? cyl[15:8] : lba_q[23:16];
      default: parm = 8'h00;
    endcase
  end

  always_comb begin
    io_req = 1'b1; io_we = 1'b0; io_sel = 4'd7; io_wdata = 16'h0000;
    case (st)
      S_CTRL:  begin io_we = 1'b1; io_sel = 4'd8; io_wdata = 16'h0002; end
      S_DEV:   begin io_we = 1'b1; io_sel = 4'd6; io_wdata = {8'h00, devsel}; end
      S_PARM:  begin io_we = 1'b1; io_sel = 4'd2 + {2'b00, pidx[1:0]}; io_wdata = {8'h00, parm}; end
      S_CMD:   begin io_we = 1'b1; io_wdata = {8'h00, cmd}; end
      S_FLUSH: begin io_we = 1'b1; io_wdata = {8'h00, flush_cmd}; end
      S_DLY:   io_sel = 4'd8;
      S_RDW:   io_sel = 4'd0;
      S_WRW:   begin io_req = s_valid; io_we = 1'b1; io_sel = 4'd0; io_wdata = s_data; end
      S_WBSY, S_STAT: ;
      default: io_req = 1'b0;
    endcase
  end

  assign io_chan = chan_q;
  assign done    = (st == S_DONE);
  assign m_valid = (st == S_RDO);
  assign m_data  = word_q;
  assign s_ready = (st == S_WRW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; err <= 2'd0; dir_q <= 1'b0; chan_q <= 1'b0; slave_q <= 1'b0;
      lba_q <= '0; nsect_q <= '0; mode_q <= M_CHS; sec_left <= '0; wcnt <= '0;
      dcnt <= '0; pidx <= '0; word_q <= '0; flushing <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dir_q <= dir_wr; chan_q <= drv_chan; slave_q <= drv_slave;
          lba_q <= lba; nsect_q <= nsect; err <= 2'd0;
          sec_left <= (nsect == '0) ? SCW'(1 << CNT_W) : {1'b0, nsect};
          mode_q <= (lba >= 32'h1000_0000) ? M_L48 : drv_lba_ok ? M_L28 : M_CHS;
          st <= S_CTRL;
        end
        S_CTRL: st <= S_WBSY;
        S_WBSY: if (!rd[7]) st <= S_DEV;
        S_DEV:  begin pidx <= is48 ? 3'd0 : 3'd4; st <= S_PARM; end
        S_PARM: if (pidx == 3'd7) st <= S_CMD; else pidx <= pidx + 3'd1;
        S_CMD:  begin flushing <= 1'b0; dcnt <= '0; st <= S_DLY; end
        S_FLUSH: begin flushing <= 1'b1; dcnt <= '0; st <= S_DLY; end
        S_DLY:  if (dcnt == DCW'(DELAY_READS - 1)) st <= S_STAT; else dcnt <= dcnt + 1'b1;
        S_STAT: if (!rd[7]) begin
          wcnt <= '0;
          if (flushing) st <= S_DONE;
          else if (dir_q) st <= S_WRW;
          else if (rd[0]) begin err <= 2'd2; st <= S_DONE; end
          else if (rd[5]) begin err <= 2'd1; st <= S_DONE; end
          else if (!rd[3]) begin err <= 2'd3; st <= S_DONE; end
          else st <= S_RDW;
        end
        S_RDW:  begin word_q <= io_rdata; st <= S_RDO; end
        S_RDO:  if (m_ready && !word_last) begin wcnt <= wcnt + 1'b1; st <= S_RDW; end
        S_WRW:  if (s_valid && !word_last) wcnt <= wcnt + 1'b1;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (sec_end) begin
        wcnt <= '0;
        if (sec_left == SCW'(1)) st <= dir_q ? S_FLUSH : S_DONE;
        else begin sec_left <= sec_left - 1'b1; dcnt <= '0; st <= S_DLY; end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_WRITE_OK: assert property (@(posedge clk) disable iff (!rst_n) done && dir_q |-> err == 2'd0); // R11
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data)); // R10
  AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && io_we && io_sel == 4'd7 |-> io_wdata == 16'h20 || io_wdata == 16'h24 ||
    io_wdata == 16'h30 || io_wdata == 16'h34 || io_wdata == 16'hE7 || io_wdata == 16'hEA); // R4
  AST_CTRL_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && io_we && io_sel == 4'd8 |-> io_wdata == 16'h0002); // R9
  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && io_we && io_sel == 4'd0 |-> s_valid && s_ready && io_wdata == s_data); // R8
endmodule

// File: tb/ata_pio_seq_tb.sv
`timescale 1ns/1ps
module ata_pio_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start = 0, dir_wr = 0, drv_chan = 0, drv_slave = 0, drv_lba_ok = 0;
  logic [31:0] lba = 0;
  logic [7:0] nsect = 0;
  logic done, io_req, io_we, io_chan, m_valid, s_ready;
  logic [1:0] err;
  logic [3:0] io_sel;
  logic [15:0] io_wdata, io_rdata, m_data, s_data;
  logic m_ready, s_valid;

  logic clr = 0, rdy_en = 0, gap_en = 0;
  logic [7:0] st_final = 8'h58;
  int bsy_left, rd_idx, wr_idx, wmis, altn, cons, cons_bad, stall_bad, order_bad, src;
  logic [7:0] first_w [16], last_w [16];
  int nw [16];
  logic [7:0] cyc;
  logic pv, pr;
  logic [15:0] pd;
  int total = 0, failed = 0;

  ata_pio_seq u_dut (.clk, .rst_n, .start, .dir_wr, .drv_chan, .drv_slave, .drv_lba_ok,
    .lba, .nsect, .done, .err, .io_req, .io_we, .io_chan, .io_sel, .io_wdata, .io_rdata,
    .m_valid, .m_ready, .m_data, .s_valid, .s_ready, .s_data);

  assign io_rdata = (io_sel == 4'd0) ? (16'(rd_idx) ^ 16'h5A5A)
                                     : {8'h00, (bsy_left != 0) ? 8'h80 : st_final};
  assign m_ready = rdy_en ? (cyc[1] ^ cyc[3]) : 1'b1;
  assign s_valid = gap_en ? (cyc[0] | cyc[2]) : 1'b1;
  assign s_data  = 16'(src) ^ 16'h1234;

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    pv <= m_valid; pr <= m_ready; pd <= m_data;
    if (clr) begin
      bsy_left <= 2; rd_idx <= 0; wr_idx <= 0; wmis <= 0; altn <= 0; cons <= 0;
      cons_bad <= 0; stall_bad <= 0; order_bad <= 0; src <= 0;
      for (int k = 0; k < 16; k++) begin nw[k] <= 0; first_w[k] <= 8'h00; last_w[k] <= 8'h00; end
    end else begin
      if (m_valid && m_ready) begin
        if (m_data !== (16'(cons) ^ 16'h5A5A)) cons_bad <= cons_bad + 1;
        cons <= cons + 1;
      end
      if (pv && !pr && (!m_valid || m_data !== pd)) stall_bad <= stall_bad + 1;
      if (s_valid && s_ready) src <= src + 1;
      if (io_req && !io_we) begin
        if (io_sel == 4'd7 && bsy_left > 0) bsy_left <= bsy_left - 1;
        if (io_sel == 4'd8) altn <= altn + 1;
        if (io_sel == 4'd0) begin
          rd_idx <= rd_idx + 1;
          if (((rd_idx + 1) % 256) == 0) bsy_left <= 2;
        end
      end
      if (io_req && io_we) begin
        if (io_sel == 4'd0) begin
          if (io_wdata !== (16'(wr_idx) ^ 16'h1234)) wmis <= wmis + 1;
          wr_idx <= wr_idx + 1;
          if (((wr_idx + 1) % 256) == 0) bsy_left <= 2;
        end else begin
          if (nw[io_sel] == 0) first_w[io_sel] <= io_wdata[7:0];
          last_w[io_sel] <= io_wdata[7:0];
          nw[io_sel] <= nw[io_sel] + 1;
          if (io_sel == 4'd6 && bsy_left != 0) order_bad <= order_bad + 1;
          if (io_sel == 4'd7) bsy_left <= 3;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic wr, input logic ok, input logic sl, input logic [31:0] a,
                     input logic [7:0] n, input logic [7:0] st);
    @(negedge clk);
    dir_wr = wr; drv_lba_ok = ok; drv_slave = sl; lba = a; nsect = n; st_final = st; clr = 1;
    @(negedge clk); clr = 0; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
  endtask

  typedef struct packed {
    logic wr; logic ok; logic sl; logic [31:0] a; logic [7:0] n;
    logic [7:0] dev; logic [7:0] cmd; logic [7:0] b0; logic [7:0] b1; logic [7:0] b2; logic [7:0] b3;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 1'b0, 32'h0123_4567, 8'd2, 8'hE1, 8'h20, 8'h67, 8'h45, 8'h23, 8'h67},
    '{1'b1, 1'b1, 1'b1, 32'h1234_5678, 8'd1, 8'hF0, 8'h34, 8'h78, 8'h56, 8'h34, 8'h12},
    '{1'b0, 1'b0, 1'b0, 32'd1000,      8'd1, 8'hAF, 8'h20, 8'h38, 8'h00, 8'h00, 8'h38},
    '{1'b1, 1'b0, 1'b1, 32'd100000,    8'd2, 8'hB3, 8'h30, 8'h14, 8'h63, 8'h00, 8'h14},
    '{1'b0, 1'b1, 1'b1, 32'h0FFF_FFFF, 8'd1, 8'hFF, 8'h20, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    '{1'b0, 1'b0, 1'b0, 32'h1000_0000, 8'd1, 8'hE0, 8'h24, 8'h00, 8'h00, 8'h00, 8'h10}
  };

  initial begin
    #760000;
    failed++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    vec_t v;
    logic l48;
    clr = 1;
    repeat (3) @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R11 reset io_req", io_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset m_valid", m_valid, 0);
    chk("R8 reset s_ready", s_ready, 0);

    for (int i = 0; i < 6; i++) begin
      v = VECS[i];
      l48 = (v.cmd == 8'h24) || (v.cmd == 8'h34);
      rdy_en = !v.wr; gap_en = v.wr;
      run(v.wr, v.ok, v.sl, v.a, v.n, 8'h58);
      chk("R11 err", err, 0);
      chk("R1 devsel", last_w[6], v.dev);
      chk("R4 command", first_w[7], v.cmd);
      chk("R2 reg3", last_w[3], v.b0);
      chk("R2 reg4", last_w[4], v.b1);
      chk("R2 reg5", last_w[5], v.b2);
      chk("R3 first reg3", first_w[3], v.b3);
      chk("R3 reg2 writes", nw[2], l48 ? 2 : 1);
      chk("R3 count low", last_w[2], v.n);
      chk("R5 last reg7", last_w[7], v.wr ? (l48 ? 8'hEA : 8'hE7) : v.cmd);
      chk("R5 reg7 writes", nw[7], v.wr ? 2 : 1);
      chk("R6 alt reads", altn, 4 * (v.n + v.wr));
      chk("R8 words", v.wr ? wr_idx : rd_idx, v.n * 256);
      chk("R8 data order", v.wr ? wmis : cons_bad, 0);
      chk("R9 ctrl", last_w[8], 8'h02);
      chk("R9 busy wait", order_bad, 0);
      if (!v.wr) begin
        chk("R8 consumed", cons, v.n * 256);
        chk("R10 stall hold", stall_bad, 0);
      end
      @(negedge clk);
      chk("R11 one cycle", done, 0);
    end

    rdy_en = 0; gap_en = 0;
    run(1'b0, 1'b1, 1'b0, 32'h40, 8'd2, 8'h59);
    chk("R7 err only", err, 2); chk("R7 no words err", rd_idx, 0);
    run(1'b0, 1'b1, 1'b0, 32'h40, 8'd2, 8'h78);
    chk("R7 df", err, 1); chk("R7 no words df", rd_idx, 0);
    run(1'b0, 1'b1, 1'b0, 32'h40, 8'd2, 8'h50);
    chk("R7 drq clear", err, 3); chk("R7 no words drq", cons, 0);
    run(1'b0, 1'b1, 1'b0, 32'h40, 8'd2, 8'h79);
    chk("R7 err over df", err, 2);
    run(1'b1, 1'b1, 1'b0, 32'h40, 8'd1, 8'h51);
    chk("R7 write ignores", err, 0); chk("R7 write words", wr_idx, 256);

    run(1'b1, 1'b1, 1'b0, 32'h5, 8'd0, 8'h58);
    chk("R8 count zero words", wr_idx, 65536);
    chk("R8 count zero data", wmis, 0);
    chk("R6 count zero alt", altn, 4 * 257);
    chk("R3 count zero reg2", nw[2], 1);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule